// File: doc/BRIEF.md
# Asynchronous Host Write Decoder

This block receives write cycles from a host over an asynchronous memory-style bus. The bus has a 16-bit data word, a short word address, an active-low chip select, an active-low write strobe and a FIFO-select line. All host inputs pass through a multi-stage synchroniser in the local clock domain. A write cycle is open while both strobes are low. It closes as soon as either strobe goes high, and the order in which the host moves the two strobes does not matter.

On every completed cycle the block issues one single-cycle pulse. The pulse carries the last address and data word seen while the cycle was open. A write goes to the transmit-FIFO push port when the FIFO-select line was high, or when the address equals the FIFO alias word. Every other write goes to the register-write port. Cycles that are too short to be real are discarded. A push that finds the FIFO full is dropped and recorded in a sticky overrun flag.

Top module: `pio_wr_decoder`

## Requirements
- R1: While reset is held, and directly after it, `reg_wr`, `fifo_push` and `overrun` are low.
- R2: Holding only one strobe low (chip select alone or write strobe alone) never produces a write.
- R3: A cycle closes when either strobe rises. Every assert order and every release order of the two strobes yields the same single write.
- R4: Each accepted cycle gives exactly one pulse, one clock wide, on either `reg_wr` or `fifo_push`, and never on both in the same clock.
- R5: The captured data word and address are the last values sampled while both strobes were low. Changes made at or after the closing strobe edge are not used.
- R6: With FIFO select low, an address equal to `FIFO_WORD_ADDR` (default 7'h10) produces a push. Any other address produces a register write on `reg_addr`.
- R7: With FIFO select high, every write is pushed to the FIFO, whatever the address.
- R8: A push that is due while `fifo_full` is high is dropped, with no pulse on `fifo_push`, and sets `overrun`. `overrun` stays high until reset, and later pushes are still accepted.
- R9: A cycle with both strobes low for fewer than `MIN_ACTIVE` (default 2) sampling clocks is discarded. A cycle of exactly `MIN_ACTIVE` clocks is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_we_n | input | 1 | Host write strobe, active low |
| host_fifo_sel | input | 1 | Forces the write to the FIFO when high |
| host_addr | input | ADDR_W | Host word address |
| host_data | input | DATA_W | Host write data |
| fifo_full | input | 1 | FIFO cannot accept a word |
| reg_wr | output | 1 | One-clock register-write pulse |
| reg_addr | output | ADDR_W | Address for the register write |
| reg_data | output | DATA_W | Data for the register write |
| fifo_push | output | 1 | One-clock FIFO push pulse |
| fifo_data | output | DATA_W | Word to push |
| overrun | output | 1 | Sticky flag: a push was dropped on a full FIFO |

## Verification
A cycle closing with a push due and `fifo_full` high at that same edge is the point where the push path and the overrun logic meet. The bench provokes it by raising `fifo_full` before a FIFO-routed write closes. It then checks that no push pulse appears, that `overrun` rises, and that the flag survives a later register write. After `fifo_full` drops, a further push is expected to go through with `overrun` still set.

// File: rtl/pio_wr_pkg.sv
package pio_wr_pkg;

   typedef enum logic [1:0] {
      DEST_NONE = 2'd0,
      DEST_REG  = 2'd1,
      DEST_FIFO = 2'd2,
      DEST_DROP = 2'd3
   } dest_e;

   function automatic dest_e pick_dest(input logic fifo_hit, input logic full);
      if (!fifo_hit)  return DEST_REG;
      else if (full)  return DEST_DROP;
      else            return DEST_FIFO;
   endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int            W       = 2,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] d_sync
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RST_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/pio_frame.sv
module pio_frame #(
   parameter int MIN_ACTIVE = 2,
   localparam int CNT_W     = $clog2(MIN_ACTIVE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_s,
   input  logic we_n_s,
   output logic active,
   output logic close_ok
);
   logic             active_q;
   logic [CNT_W-1:0] len_q;

   assign active = ~cs_n_s & ~we_n_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         len_q    <= '0;
      end else begin
         active_q <= active;
         if (!active)
            len_q <= '0;
         else if (len_q != CNT_W'(MIN_ACTIVE))
            len_q <= len_q + 1'b1;
      end
   end

   assign close_ok = active_q & ~active & (len_q == CNT_W'(MIN_ACTIVE));
endmodule

// File: rtl/pio_capture.sv
module pio_capture #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         active,
   input  logic [W-1:0] bus_s,
   output logic [W-1:0] held
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held <= '0;
      else if (active) held <= bus_s;
   end
endmodule

// File: rtl/pio_route.sv
module pio_route
   import pio_wr_pkg::*;
#(
   parameter int              ADDR_W         = 7,
   parameter int              DATA_W         = 16,
   parameter logic [ADDR_W-1:0] FIFO_WORD_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              close_ok,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   input  logic              fifo_full,
   output logic              reg_wr,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_data,
   output logic              fifo_push,
   output logic [DATA_W-1:0] fifo_data,
   output logic              overrun
);
   dest_e dest;

   always_comb begin
      dest = DEST_NONE;
      if (close_ok) dest = pick_dest(sel | (addr == FIFO_WORD_ADDR), fifo_full);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_wr    <= 1'b0;
         fifo_push <= 1'b0;
         overrun   <= 1'b0;
         reg_addr  <= '0;
         reg_data  <= '0;
         fifo_data <= '0;
      end else begin
         reg_wr    <= (dest == DEST_REG);
         fifo_push <= (dest == DEST_FIFO);
         if (dest == DEST_DROP) overrun <= 1'b1;
         if (dest == DEST_REG) begin
            reg_addr <= addr;
            reg_data <= data;
         end
         if (dest == DEST_FIFO) fifo_data <= data;
      end
   end
endmodule

// File: rtl/pio_wr_decoder.sv
module pio_wr_decoder #(
   parameter int                ADDR_W         = 7,
   parameter int                DATA_W         = 16,
   parameter int                SYNC_STAGES    = 2,
   parameter int                MIN_ACTIVE     = 2,
   parameter logic [ADDR_W-1:0] FIFO_WORD_ADDR = 7'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_cs_n,
   input  logic              host_we_n,
   input  logic              host_fifo_sel,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_data,
   input  logic              fifo_full,
   output logic              reg_wr,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [DATA_W-1:0] reg_data,
   output logic              fifo_push,
   output logic [DATA_W-1:0] fifo_data,
   output logic              overrun
);
   localparam int PAY_W = ADDR_W + DATA_W + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (MIN_ACTIVE < 1) begin : g_bad_min
      $error("MIN_ACTIVE must be at least 1");
   end
   if (DATA_W != 16) begin : g_bad_data
      $error("host data bus is 16 bits");
   end

   logic [1:0]       strb_s;
   logic [PAY_W-1:0] pay_s, pay_held;
   logic             active, close_ok;

   pio_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync_strb (
      .clk(clk), .rst_n(rst_n),
      .d_async({host_cs_n, host_we_n}), .d_sync(strb_s)
   );

   pio_sync #(.W(PAY_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_pay (
      .clk(clk), .rst_n(rst_n),
      .d_async({host_fifo_sel, host_addr, host_data}), .d_sync(pay_s)
   );

   pio_frame #(.MIN_ACTIVE(MIN_ACTIVE)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .cs_n_s(strb_s[1]), .we_n_s(strb_s[0]),
      .active(active), .close_ok(close_ok)
   );

   pio_capture #(.W(PAY_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .active(active),
      .bus_s(pay_s), .held(pay_held)
   );

   pio_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_WORD_ADDR(FIFO_WORD_ADDR)) u_route (
      .clk(clk), .rst_n(rst_n), .close_ok(close_ok),
      .sel(pay_held[PAY_W-1]),
      .addr(pay_held[DATA_W +: ADDR_W]),
      .data(pay_held[DATA_W-1:0]),
      .fifo_full(fifo_full),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
      .fifo_push(fifo_push), .fifo_data(fifo_data), .overrun(overrun)
   );
endmodule

// File: rtl/pio_wr_decoder_chk.sv
module pio_wr_decoder_chk (
   input logic clk,
   input logic rst_n,
   input logic fifo_full,
   input logic reg_wr,
   input logic fifo_push,
   input logic overrun
);
   a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && fifo_push));
   a_r4_reg_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> !reg_wr);
   a_r4_push_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |=> !fifo_push);
   a_r8_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> !$past(fifo_full));
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   a_r8_rise_on_full: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(fifo_full));
endmodule

bind pio_wr_decoder pio_wr_decoder_chk u_chk (
   .clk(clk), .rst_n(rst_n), .fifo_full(fifo_full),
   .reg_wr(reg_wr), .fifo_push(fifo_push), .overrun(overrun)
);

// File: tb/pio_wr_decoder_test.sv
module pio_wr_decoder_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_cs_n = 1'b1, host_we_n = 1'b1, host_fifo_sel = 1'b0;
   logic [6:0]  host_addr = '0;
   logic [15:0] host_data = '0;
   logic        fifo_full = 1'b0;
   logic        reg_wr, fifo_push, overrun;
   logic [6:0]  reg_addr;
   logic [15:0] reg_data, fifo_data;

   int total = 0, bad = 0;
   int n_reg = 0, n_push = 0, n_wide = 0;
   logic [15:0] last_reg_data = '0, last_push_data = '0;
   logic [6:0]  last_reg_addr = '0;
   logic        prev_reg = 1'b0, prev_push = 1'b0;

   always #4 clk = ~clk;

   pio_wr_decoder uut (
      .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_we_n(host_we_n),
      .host_fifo_sel(host_fifo_sel), .host_addr(host_addr), .host_data(host_data),
      .fifo_full(fifo_full), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_data(reg_data),
      .fifo_push(fifo_push), .fifo_data(fifo_data), .overrun(overrun)
   );

   always @(negedge clk) begin
      if (reg_wr) begin
         n_reg++; last_reg_data = reg_data; last_reg_addr = reg_addr;
         if (prev_reg) n_wide++;
      end
      if (fifo_push) begin
         n_push++; last_push_data = fifo_data;
         if (prev_push) n_wide++;
      end
      prev_reg  = reg_wr;
      prev_push = fifo_push;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic host_write(input bit cs_first, input bit rel_cs_first, input bit sel,
                             input logic [6:0] addr, input logic [15:0] data, input int act_cyc);
      @(negedge clk);
      host_fifo_sel = sel; host_addr = addr; host_data = data;
      @(negedge clk);
      if (cs_first) host_cs_n = 1'b0; else host_we_n = 1'b0;
      @(negedge clk);
      host_cs_n = 1'b0; host_we_n = 1'b0;
      repeat (act_cyc) @(negedge clk);
      if (rel_cs_first) host_cs_n = 1'b1; else host_we_n = 1'b1;
      host_data = 16'hDEAD; host_addr = 7'h55; host_fifo_sel = ~sel;
      @(negedge clk);
      host_cs_n = 1'b1; host_we_n = 1'b1;
      repeat (8) @(negedge clk);
   endtask

   typedef struct packed {
      bit        csf;
      bit        relcs;
      bit        sel;
      bit [6:0]  addr;
      bit [15:0] data;
      bit        to_fifo;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{1'b1, 1'b1, 1'b0, 7'h03, 16'h1234, 1'b0},
      '{1'b0, 1'b0, 1'b0, 7'h05, 16'hA5A5, 1'b0},
      '{1'b1, 1'b0, 1'b0, 7'h10, 16'h0F0F, 1'b1},
      '{1'b0, 1'b1, 1'b1, 7'h03, 16'hBEEF, 1'b1},
      '{1'b1, 1'b1, 1'b1, 7'h7F, 16'h0001, 1'b1},
      '{1'b0, 1'b1, 1'b0, 7'h7F, 16'hFFFF, 1'b0}
   };

   initial begin
      #1500000;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int r0, p0;
      repeat (3) @(negedge clk);
      chk("R1 reset reg_wr", reg_wr, 0);
      chk("R1 reset fifo_push", fifo_push, 0);
      chk("R1 reset overrun", overrun, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 after reset pulses", n_reg + n_push, 0);

      for (int i = 0; i < 6; i++) begin
         r0 = n_reg; p0 = n_push;
         host_write(VEC[i].csf, VEC[i].relcs, VEC[i].sel, VEC[i].addr, VEC[i].data, 3);
         // R3 R6 R7: routing for every strobe order
         chk("R3 R6 R7 reg count", n_reg - r0, VEC[i].to_fifo ? 0 : 1);
         chk("R3 R6 R7 push count", n_push - p0, VEC[i].to_fifo ? 1 : 0);
         if (VEC[i].to_fifo) chk("R5 push data", last_push_data, VEC[i].data);
         else begin
            chk("R5 reg data", last_reg_data, VEC[i].data);
            chk("R6 reg addr", last_reg_addr, VEC[i].addr);
         end
      end
      chk("R4 pulse width", n_wide, 0);

      // R2: one strobe alone
      r0 = n_reg; p0 = n_push;
      @(negedge clk); host_addr = 7'h02; host_cs_n = 1'b0;
      repeat (6) @(negedge clk); host_cs_n = 1'b1;
      repeat (8) @(negedge clk);
      host_we_n = 1'b0;
      repeat (6) @(negedge clk); host_we_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R2 single strobe no write", (n_reg - r0) + (n_push - p0), 0);

      // R9: short and boundary cycles
      r0 = n_reg;
      host_write(1'b1, 1'b1, 1'b0, 7'h04, 16'h1111, 1);
      chk("R9 one-clock cycle ignored", n_reg - r0, 0);
      host_write(1'b0, 1'b0, 1'b0, 7'h04, 16'h2222, 2);
      chk("R9 two-clock cycle accepted", n_reg - r0, 1);
      chk("R9 accepted data", last_reg_data, 16'h2222);

      // R5: data changes mid-cycle, last value wins
      r0 = n_reg;
      @(negedge clk); host_fifo_sel = 1'b0; host_addr = 7'h06; host_data = 16'h0AAA;
      @(negedge clk); host_cs_n = 1'b0; host_we_n = 1'b0;
      repeat (3) @(negedge clk); host_data = 16'h0BBB;
      repeat (3) @(negedge clk); host_we_n = 1'b1; host_data = 16'hDEAD;
      @(negedge clk); host_cs_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R5 last data wins count", n_reg - r0, 1);
      chk("R5 last data wins", last_reg_data, 16'h0BBB);

      // R8: full FIFO drops push and sets sticky overrun
      p0 = n_push;
      fifo_full = 1'b1;
      host_write(1'b1, 1'b0, 1'b1, 7'h01, 16'hC0DE, 3);
      chk("R8 dropped push", n_push - p0, 0);
      chk("R8 overrun set", overrun, 1);
      r0 = n_reg;
      host_write(1'b1, 1'b1, 1'b0, 7'h08, 16'h5151, 3);
      chk("R8 reg write while full", n_reg - r0, 1);
      chk("R8 overrun sticky", overrun, 1);
      fifo_full = 1'b0;
      host_write(1'b0, 1'b0, 1'b0, 7'h10, 16'h7777, 3);
      chk("R8 push after full clears", n_push - p0, 1);
      chk("R8 push data", last_push_data, 16'h7777);
      chk("R8 overrun still set", overrun, 1);
      chk("R4 pulse width end", n_wide, 0);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R1 overrun cleared by reset", overrun, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule